// File: doc/BRIEF.md
# Pipelined Signed Radix-32 Wallace Multiplier

This block multiplies two signed two's-complement operands (64 bits each by default) and returns the full double-width signed product. The multiplier operand is recoded into radix-32 digits in the range -16 to +16. Each digit selects a precomputed multiple of the multiplicand. With the default widths this yields 13 partial-product words. A Wallace-style carry-save tree then reduces those words to two. It uses 4:2 compressors wherever four words are available, and a 3:2 counter or a plain pass-through for the words left over. A single carry-propagate adder forms the result.

Registers sit after the recoder, after every tree level and after the final adder. The block therefore accepts one operation per cycle and returns it a fixed number of cycles later. A valid bit travels alongside the data. The operand widths are parameters, and the number of partial products, tree levels and pipeline stages follows from them.

Top module: `smul_wallace_top`

## Requirements
- R1: When out_valid is high, product equals the exact two's-complement product of the a and b sampled with the matching in_valid, as a WA+WB bit value.
- R2: A result appears after the fifth rising edge, counting the edge that samples in_valid (default widths: 13 partial products, 3 tree levels, so latency = levels + 2).
- R3: A new operation is accepted on every cycle, and back-to-back operations leave the block in issue order, one per cycle, each with its own correct product.
- R4: rst is synchronous and active high. It clears every valid stage, so out_valid is low while rst is high, and operations in flight when reset was applied never emerge.
- R5: The operand values 0, +1, -1, the largest positive value and the most negative value give exact products. This includes most-negative times most-negative = 2^126 and most-negative times -1 = +2^63.
- R6: A cycle with in_valid low produces a cycle with out_valid low one latency later. No result is emitted without a matching input.
- R7: The multiplier is read in 6-bit windows stepping by 5 bits, with a zero below bit 0 and the sign bit repeated above the top. A window w gives the digit -16*w[5] + 8*w[4] + 4*w[3] + 2*w[2] + w[1] + w[0]. Operands whose 5-bit groups alternate 01111 and 10000 (digits +16 and -16), and other dense bit patterns, give exact products.
- R8: The number of partial-product words is floor(WB/5)+1 and the tree depth follows from it. A 6-by-10 build (3 words, one 3:2 level, latency 3) is exact for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operands a and b are presented this cycle |
| a | input | WA | Signed multiplicand |
| b | input | WB | Signed multiplier (recoded operand) |
| out_valid | output | 1 | product holds a result this cycle |
| product | output | WA+WB | Signed product |

## Verification
The bench builds the block twice. The first build uses the default 64-by-64 widths, which exercise three 4:2 levels with a pass-through word, carries rippling between columns inside the compressors, and the full 128-bit sign handling of the ±16 digits. The second build uses WA=6 and WB=10. It leaves exactly three partial products, so the tree is a single 3:2 level. Its 16-bit operand space is small enough to sweep completely, covering every digit value against every multiplicand.

// File: rtl/smul_pkg.sv
package smul_pkg;

   // bits of the multiplier consumed per recoded digit
   localparam int GRP = 5;
   // largest digit magnitude
   localparam int MAXD = 1 << (GRP - 1);

   function automatic int pp_count(input int wb);
      return wb / GRP + 1;
   endfunction

   // words left after one tree level: 4:2 on each quad, 3:2 on a trailing triple
   function automatic int level_next(input int n);
      int q;
      int r;
      q = n / 4;
      r = n % 4;
      return 2 * q + ((r == 3) ? 2 : r);
   endfunction

   function automatic int level_words(input int npp, input int lv);
      int n;
      n = npp;
      for (int i = 0; i < lv; i++) n = level_next(n);
      return n;
   endfunction

   function automatic int level_total(input int npp);
      int n;
      int c;
      n = npp;
      c = 0;
      while (n > 2) begin
         n = level_next(n);
         c++;
      end
      return c;
   endfunction

   // digit = -16*w5 + 8*w4 + 4*w3 + 2*w2 + w1 + w0
   function automatic logic signed [5:0] booth_digit(input logic [5:0] w);
      return $signed({w[5], w[5:1]}) + $signed({5'b00000, w[0]});
   endfunction

endpackage

// File: rtl/smul_booth_pp.sv
module smul_booth_pp
   import smul_pkg::*;
#(
   parameter int WA = 64,
   parameter int WB = 64,
   localparam int NPP = pp_count(WB),
   localparam int WP = WA + WB
) (
   input  logic [WA-1:0]           a,
   input  logic [WB-1:0]           b,
   output logic [NPP-1:0][WP-1:0]  pp
);

   localparam int MW = WA + GRP;          // room for +/-16 * a
   localparam int BX = GRP * NPP + 1;     // extended multiplier width

   logic [BX-1:0]            b_ext;
   logic [MAXD:0][MW-1:0]    mul_tab;

   assign b_ext = {{(BX - 1 - WB){b[WB-1]}}, b, 1'b0};

   // multiples 0..16 of a: evens by shifting, odds by one add
   for (genvar m = 0; m <= MAXD; m++) begin : g_mult
      if (m == 0) begin : g_zero
         assign mul_tab[m] = '0;
      end else if (m == 1) begin : g_one
         assign mul_tab[m] = {{GRP{a[WA-1]}}, a};
      end else if ((m % 2) == 0) begin : g_even
         assign mul_tab[m] = mul_tab[m/2] << 1;
      end else begin : g_odd
         assign mul_tab[m] = mul_tab[m-1] + mul_tab[1];
      end
   end

   for (genvar k = 0; k < NPP; k++) begin : g_grp
      logic signed [5:0] dig;
      logic [4:0]        mag;
      logic [WP-1:0]     mext;
      logic [WP-1:0]     sel;

      assign dig  = booth_digit(b_ext[GRP*k +: GRP+1]);
      assign mag  = dig[5] ? 5'(-dig) : dig[4:0];
      assign mext = {{(WP - MW){mul_tab[mag][MW-1]}}, mul_tab[mag]};
      assign sel  = dig[5] ? -mext : mext;
      assign pp[k] = sel << (GRP * k);
   end

endmodule

// File: rtl/smul_cmp42.sv
module smul_cmp42 #(
   parameter int W = 128
) (
   input  logic [W-1:0] x0,
   input  logic [W-1:0] x1,
   input  logic [W-1:0] x2,
   input  logic [W-1:0] x3,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);

   logic [W-1:0] s1, co, ci, cy;

   // first counter: its column carry-out never depends on the incoming carry
   assign s1 = x0 ^ x1 ^ x2;
   assign co = (x0 & x1) | (x0 & x2) | (x1 & x2);
   assign ci = co << 1;
   // second counter absorbs the fourth word and the neighbour's carry
   assign s  = s1 ^ x3 ^ ci;
   assign cy = (s1 & x3) | (s1 & ci) | (x3 & ci);
   assign c  = cy << 1;

endmodule

// File: rtl/smul_csa32.sv
module smul_csa32 #(
   parameter int W = 128
) (
   input  logic [W-1:0] x0,
   input  logic [W-1:0] x1,
   input  logic [W-1:0] x2,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);

   logic [W-1:0] maj;

   assign s   = x0 ^ x1 ^ x2;
   assign maj = (x0 & x1) | (x0 & x2) | (x1 & x2);
   assign c   = maj << 1;

endmodule

// File: rtl/smul_level.sv
module smul_level
   import smul_pkg::*;
#(
   parameter int W  = 128,
   parameter int NI = 13,
   localparam int NO = level_next(NI)
) (
   input  logic [NI-1:0][W-1:0] in_w,
   output logic [NO-1:0][W-1:0] out_w
);

   localparam int NQ = NI / 4;
   localparam int NR = NI % 4;

   for (genvar q = 0; q < NQ; q++) begin : g_quad
      smul_cmp42 #(.W(W)) u_c42 (
         .x0 (in_w[4*q]),
         .x1 (in_w[4*q+1]),
         .x2 (in_w[4*q+2]),
         .x3 (in_w[4*q+3]),
         .s  (out_w[2*q]),
         .c  (out_w[2*q+1])
      );
   end

   if (NR == 3) begin : g_tri
      smul_csa32 #(.W(W)) u_c32 (
         .x0 (in_w[4*NQ]),
         .x1 (in_w[4*NQ+1]),
         .x2 (in_w[4*NQ+2]),
         .s  (out_w[2*NQ]),
         .c  (out_w[2*NQ+1])
      );
   end else begin : g_pass
      for (genvar r = 0; r < NR; r++) begin : g_wire
         assign out_w[2*NQ+r] = in_w[4*NQ+r];
      end
   end

endmodule

// File: rtl/smul_wallace_top.sv
module smul_wallace_top
   import smul_pkg::*;
#(
   parameter int WA = 64,
   parameter int WB = 64,
   localparam int WP = WA + WB
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [WA-1:0] a,
   input  logic [WB-1:0] b,
   output logic          out_valid,
   output logic [WP-1:0] product
);

   localparam int NPP = pp_count(WB);
   localparam int NLV = level_total(NPP);
   localparam int LAT = NLV + 2;

   if (WA < 2) begin : g_bad_wa
      $error("smul_wallace_top: WA must be at least 2");
   end
   if (WB < 2 * GRP) begin : g_bad_wb
      $error("smul_wallace_top: WB must give at least three partial products");
   end

   logic [NPP-1:0][WP-1:0] pp_c, pp_q;
   logic [LAT-1:0]         vld_q;

   smul_booth_pp #(.WA(WA), .WB(WB)) u_pp (
      .a  (a),
      .b  (b),
      .pp (pp_c)
   );

   always_ff @(posedge clk) pp_q <= pp_c;

   for (genvar lv = 0; lv < NLV; lv++) begin : g_lv
      localparam int NI = level_words(NPP, lv);
      localparam int NO = level_next(NI);
      logic [NI-1:0][WP-1:0] row_in;
      logic [NO-1:0][WP-1:0] row_c, row_q;

      if (lv == 0) begin : g_src_pp
         assign row_in = pp_q;
      end else begin : g_src_lv
         assign row_in = g_lv[lv-1].row_q;
      end

      smul_level #(.W(WP), .NI(NI)) u_lvl (
         .in_w  (row_in),
         .out_w (row_c)
      );

      always_ff @(posedge clk) row_q <= row_c;
   end

   logic [WP-1:0] fin_x, fin_y;
   assign fin_x = g_lv[NLV-1].row_q[0];
   assign fin_y = g_lv[NLV-1].row_q[1];

   always_ff @(posedge clk) product <= fin_x + fin_y;

   always_ff @(posedge clk) begin
      if (rst) vld_q <= '0;
      else     vld_q <= {vld_q[LAT-2:0], in_valid};
   end

   assign out_valid = vld_q[LAT-1];

endmodule

// File: rtl/smul_wallace_chk.sv
module smul_wallace_chk #(
   parameter int WA  = 64,
   parameter int WB  = 64,
   parameter int LAT = 5,
   localparam int WP = WA + WB
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [WA-1:0] a,
   input logic [WB-1:0] b,
   input logic          out_valid,
   input logic [WP-1:0] product
);

   logic [LAT-1:0]         v_sh;
   logic [LAT-1:0]         z_sh;
   logic [LAT-1:0][WP-1:0] ref_sh;
   logic [WP-1:0]          ref_now;

   assign ref_now = {{WB{a[WA-1]}}, a} * {{WA{b[WB-1]}}, b};

   always_ff @(posedge clk) begin
      if (rst) v_sh <= '0;
      else     v_sh <= {v_sh[LAT-2:0], in_valid};
   end

   always_ff @(posedge clk) begin
      ref_sh <= {ref_sh[LAT-2:0], ref_now};
      z_sh   <= {z_sh[LAT-2:0], (a == '0) || (b == '0)};
   end

   // R1: exact signed product
   p_product_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> product == ref_sh[LAT-1]);

   // R2, R6: valid appears exactly one latency after each accepted input
   p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid == v_sh[LAT-1]);

   // R4: first cycle after reset shows no result
   p_reset_clear_r4: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);

   // R5: a zero operand always gives a zero product
   p_zero_operand_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && z_sh[LAT-1]) |-> product == '0);

endmodule

bind smul_wallace_top smul_wallace_chk #(.WA(WA), .WB(WB), .LAT(LAT)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .a         (a),
   .b         (b),
   .out_valid (out_valid),
   .product   (product)
);

// File: tb/smul_wallace_top_tb_top.sv
module smul_wallace_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LAT   = 5;      // 13 words -> 3 levels -> 5 stages
   localparam int SB    = 512;
   localparam int NVEC  = 12;
   localparam int S_N   = 65536;  // all 6x10 operand pairs

   // {a, b, expected product}
   localparam logic [255:0] VEC [NVEC] = '{
      {64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0, 128'h0},
      {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 128'h1},
      {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 128'h1},
      {64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 128'h0000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF},
      {64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 128'hFFFF_FFFF_FFFF_FFFF_8000_0000_0000_0001},
      {64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 128'hFFFF_FFFF_FFFF_FFFF_8000_0000_0000_0000},
      {64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 128'h0000_0000_0000_0000_8000_0000_0000_0000},
      {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 128'h4000_0000_0000_0000_0000_0000_0000_0000},
      {64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 128'h3FFF_FFFF_FFFF_FFFF_0000_0000_0000_0001},
      {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 128'hC000_0000_0000_0000_8000_0000_0000_0000},
      {64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFB, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFF1},
      {64'h0000_0000_000F_4240, 64'h0000_0000_000F_4240, 128'h0000_0000_0000_0000_0000_00E8_D4A5_1000}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   int  checks = 0;
   int  errors = 0;
   int  cyc = 0;
   int  ov_seen = 0;
   bit  done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // main 64x64 build
   logic          iv = 1'b0;
   logic [63:0]   a = '0;
   logic [63:0]   b = '0;
   logic          ov;
   logic [127:0]  prod;

   smul_wallace_top dut_i (
      .clk (clk), .rst (rst), .in_valid (iv), .a (a), .b (b),
      .out_valid (ov), .product (prod)
   );

   // 6x10 build
   logic          s_iv = 1'b0;
   logic [5:0]    s_a = '0;
   logic [9:0]    s_b = '0;
   logic          s_ov;
   logic [15:0]   s_prod;
   int            s_rd = 0;

   smul_wallace_top #(.WA(6), .WB(10)) dut_s (
      .clk (clk), .rst (rst), .in_valid (s_iv), .a (s_a), .b (s_b),
      .out_valid (s_ov), .product (s_prod)
   );

   // scoreboard for the main build
   logic [127:0] sb_exp [SB];
   int           sb_cyc [SB];
   string        sb_tag [SB];
   int           wr = 0;
   int           rd = 0;

   function automatic logic [127:0] smul64(input logic [63:0] x, input logic [63:0] y);
      return {{64{x[63]}}, x} * {{64{y[63]}}, y};
   endfunction

   task automatic issue(input logic [63:0] xa, input logic [63:0] xb,
                        input logic [127:0] ex, input string tg);
      @(negedge clk);
      iv = 1'b1;
      a  = xa;
      b  = xb;
      sb_exp[wr % SB] = ex;
      sb_cyc[wr % SB] = cyc + LAT;
      sb_tag[wr % SB] = tg;
      wr++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         iv = 1'b0;
      end
   endtask

   task automatic check(input bit ok, input string tg, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
      end
   endtask

   task automatic drain();
      idle(LAT + 2);
      check(rd == wr, "R3", "results missing after drain",
            128'(wr - rd), 128'h0);
   endtask

   // monitor of the main build
   always @(negedge clk) begin
      if (!rst) begin
         if (ov) begin
            ov_seen++;
            if (rd == wr) begin
               check(1'b0, "R6", "out_valid without a pending input", 128'(prod), 128'h0);
            end else begin
               check(prod === sb_exp[rd % SB], sb_tag[rd % SB], "product",
                     prod, sb_exp[rd % SB]);
               check(cyc == sb_cyc[rd % SB], "R2", "result cycle",
                     128'(cyc), 128'(sb_cyc[rd % SB]));
               rd++;
            end
         end else if (rd != wr && cyc > sb_cyc[rd % SB]) begin
            check(1'b0, "R2", "result late or lost", 128'(cyc), 128'(sb_cyc[rd % SB]));
            rd++;
         end
      end
   end

   // monitor of the 6x10 build, exhaustive order: a = i[5:0], b = i[15:6]
   always @(negedge clk) begin
      if (!rst && s_ov) begin
         logic [5:0]  ea;
         logic [9:0]  eb;
         logic [15:0] ep;
         ea = s_rd[5:0];
         eb = s_rd[15:6];
         ep = {{10{ea[5]}}, ea} * {{6{eb[9]}}, eb};
         check(s_prod === ep, "R8", "6x10 product", 128'(s_prod), 128'(ep));
         s_rd++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] xa, xb, pat;
      int          base;

      // R4: reset state
      repeat (3) @(negedge clk);
      check(ov == 1'b0, "R4", "out_valid during reset", 128'(ov), 128'h0);
      check(s_ov == 1'b0, "R4", "6x10 out_valid during reset", 128'(s_ov), 128'h0);
      rst = 1'b0;
      idle(2);

      // vector table, back to back (R1, R5)
      for (int i = 0; i < NVEC; i++)
         issue(VEC[i][255:192], VEC[i][191:128], VEC[i][127:0], "R5");
      drain();

      // R6: idle stretch produces no result
      base = ov_seen;
      idle(LAT + 4);
      check(ov_seen == base, "R6", "results during idle", 128'(ov_seen - base), 128'h0);

      // R7: digit patterns of +16 / -16 and dense bit patterns
      pat = '0;
      for (int g = 0; g < 13; g++) begin
         for (int j = 0; j < 5; j++) begin
            if (g * 5 + j < 64) pat[g*5+j] = (g % 2 == 0) ? (j != 4) : (j == 4);
         end
      end
      issue(64'h0123_4567_89AB_CDEF, pat, smul64(64'h0123_4567_89AB_CDEF, pat), "R7");
      issue(64'hFEDC_BA98_7654_3210, ~pat, smul64(64'hFEDC_BA98_7654_3210, ~pat), "R7");
      issue(64'h8000_0000_0000_0000, pat, smul64(64'h8000_0000_0000_0000, pat), "R7");
      issue(64'h7FFF_FFFF_FFFF_FFFF, ~pat, smul64(64'h7FFF_FFFF_FFFF_FFFF, ~pat), "R7");
      issue(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA,
            smul64(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA), "R7");
      issue(64'hAAAA_AAAA_AAAA_AAAA, 64'h8421_0842_1084_2108,
            smul64(64'hAAAA_AAAA_AAAA_AAAA, 64'h8421_0842_1084_2108), "R7");
      issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h7BDE_F7BD_EF7B_DEF7,
            smul64(64'hFFFF_FFFF_FFFF_FFFF, 64'h7BDE_F7BD_EF7B_DEF7), "R7");
      drain();

      // R1, R3: random operands every cycle
      for (int i = 0; i < 200; i++) begin
         xa = {$urandom(), $urandom()};
         xb = {$urandom(), $urandom()};
         issue(xa, xb, smul64(xa, xb), "R3");
      end
      drain();

      // R2, R6: gapped issue pattern
      for (int i = 0; i < 6; i++) begin
         xa = {$urandom(), $urandom()};
         xb = {$urandom(), $urandom()};
         issue(xa, xb, smul64(xa, xb), "R1");
         idle(i % 3 + 1);
      end
      drain();

      // R4: reset with operations in flight
      for (int i = 0; i < 3; i++) begin
         xa = {$urandom(), $urandom()};
         issue(xa, 64'd7, smul64(xa, 64'd7), "R4");
      end
      @(negedge clk);
      iv  = 1'b0;
      rst = 1'b1;
      rd  = wr;
      base = ov_seen;
      @(negedge clk);
      check(ov == 1'b0, "R4", "out_valid while reset held", 128'(ov), 128'h0);
      rst = 1'b0;
      idle(LAT + 3);
      check(ov_seen == base, "R4", "flushed operations emerged", 128'(ov_seen - base), 128'h0);
      issue(64'hFFFF_FFFF_FFFF_FFF9, 64'd6, smul64(64'hFFFF_FFFF_FFFF_FFF9, 64'd6), "R4");
      drain();

      // R8: exhaustive 6x10 sweep, one pair per cycle
      for (int i = 0; i < S_N; i++) begin
         @(negedge clk);
         s_iv = 1'b1;
         s_a  = 6'(i);
         s_b  = 10'(i >> 6);
      end
      @(negedge clk);
      s_iv = 1'b0;
      repeat (6) @(negedge clk);
      check(s_rd == S_N, "R8", "6x10 result count", 128'(s_rd), 128'(S_N));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule